// File: doc/BRIEF.md
# Lasso Monitor for Liveness-to-Safety Checking

This checker sits next to a design under test and folds a set of eventuality obligations into one safety flag. The environment, or a formal engine, drives a one-bit nondeterministic capture request. On the cycle the request is high, the monitor snapshots the design's K-bit state vector into a shadow register. From then on a sticky armed flag stays set. The monitor watches for the state to come back to the snapshot, which closes a lasso.

Between the capture and the return, one sticky latch per liveness signal records whether that signal was seen high. One sticky latch per fairness signal does the same for the fairness signals. A violation is flagged when the lasso is closed, every fairness signal was seen on the loop, and at least one liveness signal was never seen. That is a fair cycle on which some obligation never happens. A new capture request restarts the recording at the new snapshot.

Top module: `lasso_monitor`

## Requirements
- R1: A synchronous active-high reset clears the armed flag, the shadow state and all liveness and fairness latches, and `violation_o` is 0 in the first cycle after reset.
- R2: The armed flag becomes 1 on the clock edge that samples `save_i` high and stays 1 until reset, whatever `save_i` does later.
- R3: The shadow state loads `state_i` on the edge that samples `save_i` high and holds its value on every other edge.
- R4: The loop condition is true only when the armed flag is set and `state_i` equals the shadow state bit for bit; before the first capture no violation is possible.
- R5: On an edge with `save_i` high, each liveness latch takes the value of its `live_i` bit. On other edges it sets if its `live_i` bit is high and the armed flag is set, and otherwise holds. Liveness signals seen before the first capture have no effect.
- R6: Fairness latches follow the rule of R5, driven by `fair_i`.
- R7: `violation_o` is combinational in the same cycle: loop condition AND all fairness latches set AND NOT all liveness latches set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| state_i | input | K | Current state vector of the design under test |
| save_i | input | 1 | Nondeterministic capture request |
| live_i | input | L | Liveness signals, one per obligation |
| fair_i | input | F | Fairness signals, one per assumption |
| violation_o | output | 1 | Fair lasso closed with an unmet liveness obligation |

## Verification
All monitor state is updated by the edge that samples the inputs. A capture, or a liveness or fairness event, therefore shows up in `violation_o` only one cycle later. A return to the captured state shows up in the same cycle, because the output is combinational from `state_i`. The bench drives every input on the falling edge and checks the output shortly after, before the next rising edge. Its expected value for that cycle comes only from stimulus applied on earlier edges plus the current `state_i`. The directed scenarios hold an event high for one cycle and check both the cycle before it takes effect and the cycle after. A randomized run compares against a cycle-level model of R2 to R7.

// File: rtl/lasso_monitor.sv
module lasso_monitor #(
  parameter int K = 4,
  parameter int L = 2,
  parameter int F = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [K-1:0] state_i,
  input  logic         save_i,
  input  logic [L-1:0] live_i,
  input  logic [F-1:0] fair_i,
  output logic         violation_o
);

  logic         armed_q;
  logic [K-1:0] shadow_q;
  logic [L-1:0] live_q;
  logic [F-1:0] fair_q;
  logic         open_win;
  logic         loop_hit;

  assign open_win = save_i | armed_q;
  assign loop_hit = armed_q & (&(state_i ~^ shadow_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      shadow_q <= '0;
    end else begin
      armed_q <= open_win;
      if (save_i) shadow_q <= state_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      fair_q <= '0;
    end else begin
      live_q <= (save_i ? '0 : live_q) | (live_i & {L{open_win}});
      fair_q <= (save_i ? '0 : fair_q) | (fair_i & {F{open_win}});
    end
  end

  assign violation_o = loop_hit & (&fair_q) & ~(&live_q);

endmodule

module lasso_monitor_chk #(
  parameter int K = 4,
  parameter int L = 2,
  parameter int F = 2
) (
  input logic         clk,
  input logic         rst,
  input logic [K-1:0] state_i,
  input logic         save_i,
  input logic [L-1:0] live_i,
  input logic [F-1:0] fair_i,
  input logic         violation_o,
  input logic         armed_q,
  input logic [K-1:0] shadow_q,
  input logic [L-1:0] live_q,
  input logic [F-1:0] fair_q
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!armed_q && live_q == '0 && fair_q == '0 && shadow_q == '0)); // R1

  AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (rst)
    (armed_q || save_i) |=> armed_q); // R2

  AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (rst)
    save_i |=> shadow_q == $past(state_i)); // R3

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !save_i |=> $stable(shadow_q)); // R3

  AST_NO_LOOP_UNARMED: assert property (@(posedge clk) disable iff (rst)
    violation_o |-> (armed_q && state_i == shadow_q)); // R4

  AST_LIVE_RESTART: assert property (@(posedge clk) disable iff (rst)
    save_i |=> live_q == $past(live_i)); // R5

  AST_FAIR_RESTART: assert property (@(posedge clk) disable iff (rst)
    save_i |=> fair_q == $past(fair_i)); // R6

  AST_VIOL_TERMS: assert property (@(posedge clk) disable iff (rst)
    violation_o |-> ((&fair_q) && !(&live_q))); // R7

endmodule

bind lasso_monitor lasso_monitor_chk #(.K(K), .L(L), .F(F)) u_lasso_chk (
  .clk(clk), .rst(rst), .state_i(state_i), .save_i(save_i),
  .live_i(live_i), .fair_i(fair_i), .violation_o(violation_o),
  .armed_q(armed_q), .shadow_q(shadow_q), .live_q(live_q), .fair_q(fair_q)
);

// File: tb/lasso_monitor_bench.sv
module lasso_monitor_bench;
  localparam int K = 4;
  localparam int L = 2;
  localparam int F = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [K-1:0] state_i = '0;
  logic         save_i = 1'b0;
  logic [L-1:0] live_i = '0;
  logic [F-1:0] fair_i = '0;
  logic         violation_o;

  int total = 0;
  int bad = 0;

  logic         m_armed;
  logic [K-1:0] m_shadow;
  logic [L-1:0] m_live;
  logic [F-1:0] m_fair;

  always #4 clk = ~clk;

  lasso_monitor #(.K(K), .L(L), .F(F)) u_lasso_monitor (
    .clk(clk), .rst(rst), .state_i(state_i), .save_i(save_i),
    .live_i(live_i), .fair_i(fair_i), .violation_o(violation_o)
  );

  task automatic check(input logic exp, input string req);
    total++;
    if (violation_o !== exp) begin
      bad++;
      $display("FAIL %s: violation_o=%b expected=%b at %0t", req, violation_o, exp, $time);
    end
  endtask

  task automatic model_edge(input logic [K-1:0] st, input logic sv,
                            input logic [L-1:0] lv, input logic [F-1:0] fv);
    logic win;
    win = sv | m_armed;
    m_live  = (sv ? '0 : m_live) | (lv & {L{win}});
    m_fair  = (sv ? '0 : m_fair) | (fv & {F{win}});
    if (sv) m_shadow = st;
    m_armed = win;
  endtask

  task automatic step(input logic [K-1:0] st, input logic sv,
                      input logic [L-1:0] lv, input logic [F-1:0] fv,
                      input logic exp, input string req);
    @(negedge clk);
    state_i = st; save_i = sv; live_i = lv; fair_i = fv;
    #1;
    check(exp, req);
    @(posedge clk);
    model_edge(st, sv, lv, fv);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; save_i = 1'b0; live_i = '0; fair_i = '0; state_i = '0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_armed = 1'b0; m_shadow = '0; m_live = '0; m_fair = '0;
  endtask

  task automatic t_reset();
    do_reset();
    step(4'd0, 1'b0, 2'b00, 2'b11, 1'b0, "R1");
    step(4'd0, 1'b0, 2'b00, 2'b11, 1'b0, "R4");
  endtask

  task automatic t_lasso();
    do_reset();
    step(4'd5, 1'b1, 2'b00, 2'b11, 1'b0, "R2");
    step(4'd6, 1'b0, 2'b01, 2'b00, 1'b0, "R4");
    step(4'd5, 1'b0, 2'b00, 2'b00, 1'b1, "R7");
    step(4'd5, 1'b0, 2'b10, 2'b00, 1'b1, "R5");
    step(4'd5, 1'b0, 2'b00, 2'b00, 1'b0, "R5");
    step(4'd5, 1'b0, 2'b00, 2'b00, 1'b0, "R2");
  endtask

  task automatic t_fair_partial();
    step(4'd9, 1'b1, 2'b00, 2'b01, 1'b0, "R6");
    step(4'd9, 1'b0, 2'b00, 2'b00, 1'b0, "R6");
    step(4'd9, 1'b0, 2'b00, 2'b10, 1'b0, "R6");
    step(4'd9, 1'b0, 2'b00, 2'b00, 1'b1, "R5");
  endtask

  task automatic t_shadow_hold();
    step(4'd3, 1'b1, 2'b11, 2'b11, 1'b0, "R3");
    step(4'd3, 1'b0, 2'b00, 2'b00, 1'b0, "R5");
    step(4'd3, 1'b1, 2'b00, 2'b11, 1'b0, "R3");
    step(4'd8, 1'b0, 2'b00, 2'b00, 1'b0, "R3");
    step(4'd3, 1'b0, 2'b00, 2'b00, 1'b1, "R3");
  endtask

  task automatic t_pre_save_ignored();
    do_reset();
    step(4'd2, 1'b0, 2'b00, 2'b11, 1'b0, "R6");
    step(4'd2, 1'b1, 2'b00, 2'b00, 1'b0, "R6");
    step(4'd2, 1'b0, 2'b00, 2'b00, 1'b0, "R6");
    do_reset();
    step(4'd2, 1'b0, 2'b11, 2'b00, 1'b0, "R5");
    step(4'd2, 1'b1, 2'b00, 2'b11, 1'b0, "R5");
    step(4'd2, 1'b0, 2'b00, 2'b00, 1'b1, "R5");
  endtask

  task automatic t_random();
    do_reset();
    for (int i = 0; i < 400; i++) begin
      logic [K-1:0] st;
      logic sv;
      logic [L-1:0] lv;
      logic [F-1:0] fv;
      logic exp;
      st = K'($urandom_range(0, 3));
      sv = ($urandom_range(0, 7) == 0);
      lv = L'($urandom_range(0, 3)) & L'($urandom_range(0, 3));
      fv = F'($urandom_range(0, 3));
      exp = m_armed && (st == m_shadow) && (&m_fair) && !(&m_live);
      step(st, sv, lv, fv, exp, "R7");
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_lasso();
    t_fair_partial();
    t_shadow_hold();
    t_pre_save_ignored();
    t_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule